// File: doc/BRIEF.md
# Strobed Input Handshake Port

This block is a single latching input port for a parallel peripheral controller. An external device places a byte on the data pins and pulses an active-low strobe. When the strobe returns high, the byte is captured into a holding register. The port then raises a buffer-full flag and, if interrupts are enabled, an interrupt request.

The CPU reads the byte through an active-low read strobe. The interrupt request drops as soon as the read begins. Buffer-full drops when the read ends. The interrupt enable is an internal bit. Software writes it with the same bit set/reset command word that addresses individual control-port bits.

A parameter builds the block as the first or second port of the controller. The two builds differ in which control-port pins carry the flags and which command bit holds the enable. The strobe and read inputs are asynchronous and pass through a two-stage synchronizer before edge detection. There is no back-pressure toward the external device: the data path has no ready signal. A strobe that arrives before the CPU has read the previous byte overwrites it. The data output is a plain level that stays valid for as long as buffer-full is high.

Top module: `sip_strobed_in`

## Requirements
- R1: After reset, buffer-full, interrupt request, the enable bit and the data output are all 0.
- R2: A low-to-high transition on `stb_n_i` latches `ext_data_i` into `rd_data_o` and sets buffer-full. Both are visible by the third rising clock edge after the transition.
- R3: Buffer-full stays set until `rd_n_i` returns high after a read. It is then clear by the third rising clock edge after that return.
- R4: `intr_o` is high exactly when a captured byte is pending and the enable bit is 1.
- R5: A high-to-low transition on `rd_n_i` clears the interrupt request within three clock edges. Buffer-full stays set while `rd_n_i` is low.
- R6: A command write with `cmd_data_i[7]`=0 and `cmd_data_i[6:4]`=0 is a bit set/reset. `cmd_data_i[3:1]` selects a bit number and `cmd_data_i[0]` is the new value. The enable takes that value when the bit number is 4 in the first-port build or 2 in the second-port build. Any other bit number, or non-zero bits 6:4, leaves the enable unchanged.
- R7: A command write with `cmd_data_i[7]`=1 (a mode word) leaves the enable unchanged.
- R8: A strobe while buffer-full is set replaces the held byte, and buffer-full stays set.
- R9: In the first-port build, buffer-full drives `pc_out_o[5]` and the interrupt request drives `pc_out_o[3]`, with `pc_oe_o`=0x28. In the second-port build, buffer-full drives `pc_out_o[1]` and the interrupt request drives `pc_out_o[0]`, with `pc_oe_o`=0x03. All other `pc_out_o` bits are 0, so bits 7 and 6 are left to general-purpose use.
- R10: Changing the enable while a byte is pending raises or drops `intr_o` one clock later, and the pending byte is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_data_i | input | DATA_W | Data from the external device |
| stb_n_i | input | 1 | Asynchronous active-low strobe from the device |
| rd_n_i | input | 1 | Asynchronous active-low CPU read of this port |
| cmd_wr_i | input | 1 | One-cycle command write pulse |
| cmd_data_i | input | 8 | Command word |
| rd_data_o | output | DATA_W | Held byte |
| ibf_o | output | 1 | Buffer-full flag |
| intr_o | output | 1 | Interrupt request |
| pc_out_o | output | 8 | Flag values placed at their control-port pin positions |
| pc_oe_o | output | 8 | Mask of control-port pins this block drives |

## Verification
The bench builds the block twice, once for each port, with the default 8-bit data width. Both copies receive the same stimulus. All 256 byte values pass through both ports. Each value chooses its own enable settings, whether an overwrite precedes it, and whether ignored mode words or malformed set/reset words are sent. This sweep covers every enable combination in both pin maps and shows that a command aimed at one port's bit has no effect on the other port.

// File: rtl/sip_pkg.sv
package sip_pkg;
  typedef enum logic {
    SIP_PORT_A = 1'b0,
    SIP_PORT_B = 1'b1
  } sip_port_e;

  function automatic int ibf_pin(sip_port_e p);
    return (p == SIP_PORT_A) ? 5 : 1;
  endfunction

  function automatic int intr_pin(sip_port_e p);
    return (p == SIP_PORT_A) ? 3 : 0;
  endfunction

  function automatic int ie_bit(sip_port_e p);
    return (p == SIP_PORT_A) ? 4 : 2;
  endfunction
endpackage

// File: rtl/sip_edge_sync.sv
module sip_edge_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE_LV}};
      prev_q <= IDLE_LV;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sip_cmd_dec.sv
module sip_cmd_dec #(
  parameter int IE_BIT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       ie_o
);
  logic ie_q;
  logic hit;

  assign hit = wr_i && !wdata_i[7] && (wdata_i[6:4] == 3'b000)
               && (wdata_i[3:1] == 3'(IE_BIT));

  always_ff @(posedge clk) begin
    if (!rst_n) ie_q <= 1'b0;
    else if (hit) ie_q <= wdata_i[0];
  end

  assign ie_o = ie_q;

  // R7: mode words never touch the enable
  a_r7_mode_word_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && wdata_i[7]) |=> $stable(ie_q));
endmodule

// File: rtl/sip_hs_ctrl.sv
module sip_hs_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_i,
  input  logic              stb_rise_i,
  input  logic              rd_fall_i,
  input  logic              rd_rise_i,
  input  logic              ie_i,
  output logic [DATA_W-1:0] latch_o,
  output logic              ibf_o,
  output logic              intr_o
);
  logic [DATA_W-1:0] latch_q;
  logic              ibf_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= '0;
      ibf_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else if (stb_rise_i) begin
      latch_q <= data_i;
      ibf_q   <= 1'b1;
      pend_q  <= 1'b1;
    end else begin
      if (rd_rise_i) begin
        ibf_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (rd_fall_i) pend_q <= 1'b0;
    end
  end

  assign latch_o = latch_q;
  assign ibf_o   = ibf_q;
  assign intr_o  = pend_q & ie_i;

  a_r2_ibf_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ibf_q) |-> $past(stb_rise_i));
  a_r4_intr_needs_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    intr_o |-> ibf_q);
  a_r5_read_start_drops_intr: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fall_i && !stb_rise_i) |=> !intr_o);
  a_r3_read_end_drops_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise_i && !stb_rise_i) |=> !ibf_q);
  a_r8_overwrite_keeps_ibf: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise_i && ibf_q) |=> ibf_q);
endmodule

// File: rtl/sip_strobed_in.sv
module sip_strobed_in
  import sip_pkg::*;
#(
  parameter sip_port_e PORT_SEL    = SIP_PORT_A,
  parameter int        DATA_W      = 8,
  parameter int        SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ext_data_i,
  input  logic              stb_n_i,
  input  logic              rd_n_i,
  input  logic              cmd_wr_i,
  input  logic [7:0]        cmd_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ibf_o,
  output logic              intr_o,
  output logic [7:0]        pc_out_o,
  output logic [7:0]        pc_oe_o
);
  localparam int IBF_PIN  = ibf_pin(PORT_SEL);
  localparam int INTR_PIN = intr_pin(PORT_SEL);
  localparam int IE_BIT   = ie_bit(PORT_SEL);

  logic stb_rise, stb_fall, rd_rise, rd_fall, ie;
  logic ibf, intr;

  sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .async_i(stb_n_i),
    .rise_o(stb_rise), .fall_o(stb_fall));

  sip_edge_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_rd_sync (
    .clk(clk), .rst_n(rst_n), .async_i(rd_n_i),
    .rise_o(rd_rise), .fall_o(rd_fall));

  sip_cmd_dec #(.IE_BIT(IE_BIT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_i(cmd_wr_i), .wdata_i(cmd_data_i),
    .ie_o(ie));

  sip_hs_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .data_i(ext_data_i),
    .stb_rise_i(stb_rise), .rd_fall_i(rd_fall), .rd_rise_i(rd_rise),
    .ie_i(ie), .latch_o(rd_data_o), .ibf_o(ibf), .intr_o(intr));

  assign ibf_o  = ibf;
  assign intr_o = intr;

  for (genvar i = 0; i < 8; i++) begin : g_pc
    if (i == IBF_PIN) begin : g_ibf
      assign pc_out_o[i] = ibf;
      assign pc_oe_o[i]  = 1'b1;
    end else if (i == INTR_PIN) begin : g_intr
      assign pc_out_o[i] = intr;
      assign pc_oe_o[i]  = 1'b1;
    end else begin : g_free
      assign pc_out_o[i] = 1'b0;
      assign pc_oe_o[i]  = 1'b0;
    end
  end

  // R2: strobe falling edge alone changes nothing visible
  a_r2_fall_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_fall && !ibf) |=> !ibf);
endmodule

// File: tb/sip_strobed_in_tb_top.sv
module sip_strobed_in_tb_top;
  import sip_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] ext_data = 8'h00;
  logic       stb_n = 1'b1;
  logic       rd_n = 1'b1;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;

  logic [7:0] rd_a, rd_b, pco_a, pco_b, oe_a, oe_b;
  logic       ibf_a, ibf_b, intr_a, intr_b;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sip_strobed_in #(.PORT_SEL(SIP_PORT_A)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_data_i(ext_data), .stb_n_i(stb_n),
    .rd_n_i(rd_n), .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data),
    .rd_data_o(rd_a), .ibf_o(ibf_a), .intr_o(intr_a),
    .pc_out_o(pco_a), .pc_oe_o(oe_a));

  sip_strobed_in #(.PORT_SEL(SIP_PORT_B)) dut_pb_i (
    .clk(clk), .rst_n(rst_n), .ext_data_i(ext_data), .stb_n_i(stb_n),
    .rd_n_i(rd_n), .cmd_wr_i(cmd_wr), .cmd_data_i(cmd_data),
    .rd_data_o(rd_b), .ibf_o(ibf_b), .intr_o(intr_b),
    .pc_out_o(pco_b), .pc_oe_o(oe_b));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cmd(logic [7:0] w);
    cmd_data = w;
    cmd_wr = 1'b1;
    step(1);
    cmd_wr = 1'b0;
  endtask

  task automatic strobe(logic [7:0] d);
    ext_data = d;
    stb_n = 1'b0;
    step(3);
    stb_n = 1'b1;
    step(4);
  endtask

  function automatic logic [7:0] map_a(logic f, logic i);
    return {2'b00, f, 1'b0, i, 3'b000};
  endfunction

  function automatic logic [7:0] map_b(logic f, logic i);
    return {6'b0, f, i};
  endfunction

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk("R1", "ibf A", ibf_a, 0);
    chk("R1", "ibf B", ibf_b, 0);
    chk("R1", "intr A", intr_a, 0);
    chk("R1", "intr B", intr_b, 0);
    chk("R1", "data A", rd_a, 0);
    chk("R1", "data B", rd_b, 0);
    // R9 fixed drive masks
    chk("R9", "oe A", oe_a, 8'h28);
    chk("R9", "oe B", oe_b, 8'h03);

    for (int v = 0; v < 256; v++) begin
      logic [7:0] d = 8'(v);
      // R6 enable for each build
      cmd({4'b0000, 3'd4, d[0]});
      cmd({4'b0000, 3'd2, d[1]});
      if (d[7]) begin  // R7 mode words that would flip enables if decoded
        cmd({1'b1, 3'b000, 3'd4, ~d[0]});
        cmd({1'b1, 3'b000, 3'd2, ~d[1]});
      end
      if (d[5]) begin  // R6 non-zero bits 6:4 ignored
        cmd({1'b0, 3'b010, 3'd4, ~d[0]});
        cmd({1'b0, 3'b001, 3'd2, ~d[1]});
      end
      if (d[6]) strobe(~d);
      strobe(d);
      chk(d[6] ? "R8" : "R2", "data A", rd_a, d);
      chk(d[6] ? "R8" : "R2", "data B", rd_b, d);
      chk("R2", "ibf A", ibf_a, 1);
      chk("R2", "ibf B", ibf_b, 1);
      chk(d[7] ? "R7" : "R4", "intr A", intr_a, d[0]);
      chk(d[5] ? "R6" : "R4", "intr B", intr_b, d[1]);
      chk("R9", "pins A", pco_a, map_a(1'b1, d[0]));
      chk("R9", "pins B", pco_b, map_b(1'b1, d[1]));
      rd_n = 1'b0;
      step(4);
      chk("R5", "intr A in read", intr_a, 0);
      chk("R5", "intr B in read", intr_b, 0);
      chk("R5", "ibf A in read", ibf_a, 1);
      chk("R5", "ibf B in read", ibf_b, 1);
      rd_n = 1'b1;
      step(4);
      chk("R3", "ibf A after read", ibf_a, 0);
      chk("R3", "ibf B after read", ibf_b, 0);
      chk("R9", "pins A idle", pco_a, 8'h00);
      chk("R9", "pins B idle", pco_b, 8'h00);
    end

    // R10 enable toggled while a byte waits
    cmd(8'h08);
    cmd(8'h04);
    strobe(8'hA5);
    chk("R10", "intr A disabled", intr_a, 0);
    chk("R10", "intr B disabled", intr_b, 0);
    cmd(8'h09);
    chk("R10", "intr A enabled late", intr_a, 1);
    chk("R10", "intr B untouched", intr_b, 0);
    cmd(8'h05);
    chk("R10", "intr B enabled late", intr_b, 1);
    cmd(8'h08);
    chk("R10", "intr A dropped", intr_a, 0);
    chk("R10", "ibf A kept", ibf_a, 1);
    chk("R10", "data A kept", rd_a, 8'hA5);
    cmd(8'h09);
    chk("R10", "intr A back", intr_a, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule